// File: doc/BRIEF.md
# Periodic SPI Burst Sequencer

This block is an SPI master that runs with no processor involvement. Each trigger starts one group of fixed-size words. The trigger comes either from an internal period counter or from a rising edge on an external pin. The block reads each word from a transmit buffer through a word-addressed read port. It shifts the word out while it shifts a reply word in, full duplex. It writes the reply to a receive buffer at the same index.

Chip select is dropped for each word and raised again after it. Between words it stays high for a fixed gap, so every word of a group starts at an exact, constant interval. At the end of a group the word pointer returns to zero, so the next trigger reuses the same buffers.

The serial clock idles low. Data leaves on the falling edge and is sampled on the rising edge, most significant bit first. A trigger that arrives while a group is still running is dropped and recorded in a sticky flag.

Top module: `spi_burst_seq`

## Requirements
- R1: One group moves exactly WORDS words (default 16). tx_addr steps from 0 to WORDS-1 in order. Each word leaves on mosi with its most significant bit first.
- R2: The bit read from miso on each rising sclk edge is shifted in, MSB first. The received word is written with a single-cycle rx_we pulse, with rx_addr equal to the index of the word that was sent.
- R3: sclk is low whenever cs_n is high. Each word has exactly WORD_BITS rising sclk edges. mosi changes only while sclk falls, or when a word starts.
- R4: cs_n stays low for exactly (2·WORD_BITS+1)·HALF_DIV system cycles per word. That is one half sclk period before the first rising edge and one half period after the last falling edge, where a half period is HALF_DIV cycles.
- R5: Between two words, cs_n stays high for 2·GAP_SCLK·HALF_DIV+1 cycles. Consecutive cs_n falling edges within a group are therefore (2·WORD_BITS+1)·HALF_DIV + 2·GAP_SCLK·HALF_DIV + 1 cycles apart.
- R6: With USE_INT_TRIG=0, a rising edge on ext_trig while the block is idle starts a group. busy stays high from the start of the group until the gap after its last word has ended.
- R7: A trigger that arrives while busy is high is ignored: no extra group follows. It sets overrun, which stays at 1 until reset.
- R8: Every group starts again at word index 0, for both tx_addr and rx_addr.
- R9: done is high for exactly one cycle: the cycle after the rx_we pulse of the last word.
- R10: With USE_INT_TRIG=1, a group starts every PERIOD_CYC cycles, and ext_trig has no effect.
- R11: After reset, the outputs are as follows: cs_n=1, sclk=0, mosi=0, busy=0, done=0, rx_we=0 and overrun=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_trig | input | 1 | External trigger; its rising edge starts a group when the internal counter is disabled |
| tx_addr | output | $clog2(WORDS) | Word index read from the transmit buffer |
| tx_data | input | WORD_BITS | Transmit word at tx_addr, available in the same cycle |
| rx_we | output | 1 | Write strobe for the receive buffer |
| rx_addr | output | $clog2(WORDS) | Word index written in the receive buffer |
| rx_data | output | WORD_BITS | Received word |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select, pulsed for each word |
| busy | output | 1 | A group is in progress |
| done | output | 1 | One-cycle pulse when a group has finished |
| overrun | output | 1 | Sticky flag: a trigger arrived while busy |

## Verification
A wrong bit phase or an off-by-one in the phase counter shows up within the first word. The cs_n low time comes out wrong, the count of sclk rises per frame is wrong, and the captured mosi word is shifted. A bad word index or a missing rewind shows up at the first rx_we pulse of the group concerned, as a wrong rx_addr. A broken gap counter changes the spacing between cs_n falls at the second word. Trigger-handling faults show up within one gap after the group ends: either an extra frame appears or overrun is wrong.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RUN  = 2'd1,
    SEQ_GAP  = 2'd2
  } seq_state_t;
endpackage

// File: rtl/burst_trigger.sv
module burst_trigger #(
  parameter int USE_INT_TRIG = 1,
  parameter int PERIOD_CYC   = 25000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_trig,
  output logic trig
);
  logic ext_prev_q;
  logic ext_edge;
  logic int_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_prev_q <= 1'b0;
    else        ext_prev_q <= ext_trig;
  end

  assign ext_edge = ext_trig & ~ext_prev_q;

  generate
    if (USE_INT_TRIG != 0) begin : g_int
      localparam int CNT_W = (PERIOD_CYC > 1) ? $clog2(PERIOD_CYC) : 1;
      logic [CNT_W-1:0] cnt_q, cnt_d;

      assign int_tick = (cnt_q == CNT_W'(PERIOD_CYC - 1));

      always_comb begin
        if (int_tick) cnt_d = '0;
        else          cnt_d = cnt_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end
    end else begin : g_ext
      assign int_tick = 1'b0;
    end
  endgenerate

  assign trig = (USE_INT_TRIG != 0) ? int_tick : ext_edge;
endmodule

// File: rtl/burst_spi_shifter.sv
module burst_spi_shifter #(
  parameter int WORD_BITS = 16,
  parameter int HALF_DIV  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [WORD_BITS-1:0] load_word,
  input  logic                 miso,
  output logic                 sclk,
  output logic                 mosi,
  output logic                 cs_act,
  output logic                 word_done,
  output logic [WORD_BITS-1:0] rx_word
);
  localparam int LAST_PH = 2 * WORD_BITS;
  localparam int PH_W    = $clog2(LAST_PH + 1);
  localparam int DIV_W   = $clog2(HALF_DIV + 1);

  logic                 act_q, act_d;
  logic [PH_W-1:0]      ph_q, ph_d;
  logic [DIV_W-1:0]     div_q, div_d;
  logic                 sclk_q, sclk_d;
  logic [WORD_BITS-1:0] txs_q, txs_d;
  logic [WORD_BITS-1:0] rxs_q, rxs_d;
  logic                 done_q, done_d;
  logic                 tick;

  assign tick = act_q && (div_q == DIV_W'(HALF_DIV - 1));

  always_comb begin
    act_d  = act_q;
    ph_d   = ph_q;
    div_d  = div_q;
    sclk_d = sclk_q;
    txs_d  = txs_q;
    rxs_d  = rxs_q;
    done_d = 1'b0;
    if (!act_q) begin
      if (start) begin
        act_d  = 1'b1;
        ph_d   = '0;
        div_d  = '0;
        sclk_d = 1'b0;
        txs_d  = load_word;
      end
    end else if (tick) begin
      div_d = '0;
      if (ph_q == PH_W'(LAST_PH)) begin
        act_d  = 1'b0;
        done_d = 1'b1;
      end else begin
        ph_d = ph_q + 1'b1;
        if (!ph_q[0]) begin
          sclk_d = 1'b1;
          rxs_d  = {rxs_q[WORD_BITS-2:0], miso};
        end else begin
          sclk_d = 1'b0;
          txs_d  = txs_q << 1;
        end
      end
    end else begin
      div_d = div_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      ph_q   <= '0;
      div_q  <= '0;
      sclk_q <= 1'b0;
      txs_q  <= '0;
      rxs_q  <= '0;
      done_q <= 1'b0;
    end else begin
      act_q  <= act_d;
      ph_q   <= ph_d;
      div_q  <= div_d;
      sclk_q <= sclk_d;
      txs_q  <= txs_d;
      rxs_q  <= rxs_d;
      done_q <= done_d;
    end
  end

  assign sclk      = sclk_q;
  assign mosi      = act_q & txs_q[WORD_BITS-1];
  assign cs_act    = act_q;
  assign word_done = done_q;
  assign rx_word   = rxs_q;
endmodule

// File: rtl/burst_sequencer.sv
module burst_sequencer
  import spi_burst_pkg::*;
#(
  parameter int WORDS   = 16,
  parameter int GAP_CYC = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     trig,
  input  logic                     word_done,
  output logic                     start,
  output logic [$clog2(WORDS)-1:0] word_idx,
  output logic                     rx_we,
  output logic                     busy,
  output logic                     done,
  output logic                     overrun
);
  localparam int IDX_W = $clog2(WORDS);
  localparam int GAP_W = $clog2(GAP_CYC + 1);

  seq_state_t       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [GAP_W-1:0] gap_q, gap_d;
  logic             last_q, last_d;
  logic             done_q, done_d;
  logic             ovr_q, ovr_d;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    gap_d   = gap_q;
    last_d  = last_q;
    done_d  = 1'b0;
    start   = 1'b0;
    rx_we   = 1'b0;
    ovr_d   = ovr_q | (trig && (state_q != SEQ_IDLE));
    case (state_q)
      SEQ_IDLE: begin
        if (trig) begin
          start   = 1'b1;
          state_d = SEQ_RUN;
        end
      end
      SEQ_RUN: begin
        if (word_done) begin
          rx_we   = 1'b1;
          gap_d   = '0;
          state_d = SEQ_GAP;
          if (idx_q == IDX_W'(WORDS - 1)) begin
            idx_d  = '0;
            last_d = 1'b1;
            done_d = 1'b1;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      SEQ_GAP: begin
        if (gap_q == GAP_W'(GAP_CYC - 1)) begin
          gap_d = '0;
          if (last_q) begin
            last_d  = 1'b0;
            state_d = SEQ_IDLE;
          end else begin
            start   = 1'b1;
            state_d = SEQ_RUN;
          end
        end else begin
          gap_d = gap_q + 1'b1;
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      idx_q   <= '0;
      gap_q   <= '0;
      last_q  <= 1'b0;
      done_q  <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      gap_q   <= gap_d;
      last_q  <= last_d;
      done_q  <= done_d;
      ovr_q   <= ovr_d;
    end
  end

  assign word_idx = idx_q;
  assign busy     = (state_q != SEQ_IDLE);
  assign done     = done_q;
  assign overrun  = ovr_q;
endmodule

// File: rtl/spi_burst_seq.sv
module spi_burst_seq #(
  parameter int WORD_BITS    = 16,
  parameter int WORDS        = 16,
  parameter int HALF_DIV     = 2,
  parameter int GAP_SCLK     = 2,
  parameter int PERIOD_CYC   = 25000,
  parameter int USE_INT_TRIG = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ext_trig,
  output logic [$clog2(WORDS)-1:0] tx_addr,
  input  logic [WORD_BITS-1:0]     tx_data,
  output logic                     rx_we,
  output logic [$clog2(WORDS)-1:0] rx_addr,
  output logic [WORD_BITS-1:0]     rx_data,
  output logic                     sclk,
  output logic                     mosi,
  input  logic                     miso,
  output logic                     cs_n,
  output logic                     busy,
  output logic                     done,
  output logic                     overrun
);
  localparam int GAP_CYC = 2 * GAP_SCLK * HALF_DIV;
  localparam int IDX_W   = $clog2(WORDS);

  logic             trig;
  logic             start;
  logic             cs_act;
  logic             word_done;
  logic [IDX_W-1:0] word_idx;

  burst_trigger #(
    .USE_INT_TRIG(USE_INT_TRIG),
    .PERIOD_CYC  (PERIOD_CYC)
  ) u_trig (
    .clk     (clk),
    .rst_n   (rst_n),
    .ext_trig(ext_trig),
    .trig    (trig)
  );

  burst_sequencer #(
    .WORDS  (WORDS),
    .GAP_CYC(GAP_CYC)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .trig     (trig),
    .word_done(word_done),
    .start    (start),
    .word_idx (word_idx),
    .rx_we    (rx_we),
    .busy     (busy),
    .done     (done),
    .overrun  (overrun)
  );

  burst_spi_shifter #(
    .WORD_BITS(WORD_BITS),
    .HALF_DIV (HALF_DIV)
  ) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .load_word(tx_data),
    .miso     (miso),
    .sclk     (sclk),
    .mosi     (mosi),
    .cs_act   (cs_act),
    .word_done(word_done),
    .rx_word  (rx_data)
  );

  assign tx_addr = word_idx;
  assign rx_addr = word_idx;
  assign cs_n    = ~cs_act;
endmodule

// File: rtl/spi_burst_seq_chk.sv
module spi_burst_seq_chk #(
  parameter int GAP_CYC = 8
) (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sclk,
  input logic rx_we,
  input logic done,
  input logic busy,
  input logic overrun
);
  localparam int CNT_W = $clog2(GAP_CYC + 2) + 1;
  localparam logic [CNT_W-1:0] HI_SAT = CNT_W'(GAP_CYC + 1);

  logic [CNT_W-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     hi_cnt <= HI_SAT;
    else if (!cs_n)                 hi_cnt <= '0;
    else if (hi_cnt != HI_SAT)      hi_cnt <= hi_cnt + 1'b1;
  end

  // R3
  cs_idle_sclk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  // R3
  sclk_moves_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk != $past(sclk)) |-> !cs_n);

  // R5
  cs_gap_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> (hi_cnt >= CNT_W'(GAP_CYC)));

  // R2
  write_at_frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_we |-> (cs_n && !$past(cs_n)));

  // R9
  done_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(rx_we));

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  idle_cs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs_n);

  // R7
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
endmodule

bind spi_burst_seq spi_burst_seq_chk #(
  .GAP_CYC(2 * GAP_SCLK * HALF_DIV)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .cs_n   (cs_n),
  .sclk   (sclk),
  .rx_we  (rx_we),
  .done   (done),
  .busy   (busy),
  .overrun(overrun)
);

// File: tb/tb_spi_burst_seq.sv
module tb_spi_burst_seq;
  localparam int WB    = 16;
  localparam int NW    = 16;
  localparam int HD    = 2;
  localparam int GS    = 2;
  localparam int PER2  = 3000;
  localparam int LOW_CYC  = (2 * WB + 1) * HD;
  localparam int WORD_PER = LOW_CYC + 2 * GS * HD + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          ext_trig = 1'b0;
  logic [3:0]    tx_addr, rx_addr;
  logic [WB-1:0] tx_data, rx_data;
  logic          rx_we, sclk, mosi, cs_n, busy, done, overrun;
  logic          miso = 1'b0;

  logic [WB-1:0] tx_mem [NW];
  logic [WB-1:0] slv_mem[NW];
  assign tx_data = tx_mem[tx_addr];

  spi_burst_seq #(.WORD_BITS(WB), .WORDS(NW), .HALF_DIV(HD), .GAP_SCLK(GS),
                  .PERIOD_CYC(PER2), .USE_INT_TRIG(0)) dut (
    .clk(clk), .rst_n(rst_n), .ext_trig(ext_trig), .tx_addr(tx_addr),
    .tx_data(tx_data), .rx_we(rx_we), .rx_addr(rx_addr), .rx_data(rx_data),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n), .busy(busy),
    .done(done), .overrun(overrun));

  logic          ext2 = 1'b0;
  logic [3:0]    tx_addr2, rx_addr2;
  logic [WB-1:0] rx_data2;
  logic          rx_we2, sclk2, mosi2, cs_n2, busy2, done2, ovr2;

  spi_burst_seq #(.WORD_BITS(WB), .WORDS(NW), .HALF_DIV(HD), .GAP_SCLK(GS),
                  .PERIOD_CYC(PER2), .USE_INT_TRIG(1)) dut_per (
    .clk(clk), .rst_n(rst_n), .ext_trig(ext2), .tx_addr(tx_addr2),
    .tx_data(16'h0000), .rx_we(rx_we2), .rx_addr(rx_addr2), .rx_data(rx_data2),
    .sclk(sclk2), .mosi(mosi2), .miso(1'b0), .cs_n(cs_n2), .busy(busy2),
    .done(done2), .overrun(ovr2));

  int n_chk = 0;
  int n_fail = 0;
  bit ended = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  // scoreboard queues
  logic [WB-1:0] exp_mosi[$];
  logic [19:0]   exp_rx[$];
  int            slv_k = 0;
  int            done_cnt = 0;

  // SPI slave model and frame monitor (R1, R3, R4, R5)
  logic          prev_cs = 1'b1, prev_sclk = 1'b0;
  logic [WB-1:0] s_sr, cap;
  int            rises, low_cnt, last_fall = -1;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_cs && !cs_n) begin
        if (slv_k > 0 && last_fall >= 0)
          chk(cyc - last_fall == WORD_PER, "R5 word spacing", cyc - last_fall, WORD_PER);
        last_fall = cyc;
        s_sr = slv_mem[slv_k];
        miso = s_sr[WB-1];
        cap = '0; rises = 0; low_cnt = 0;
      end
      if (!cs_n) begin
        low_cnt++;
        if (!prev_sclk && sclk) begin
          cap = {cap[WB-2:0], mosi};
          rises++;
        end
        if (prev_sclk && !sclk) begin
          s_sr = s_sr << 1;
          miso = s_sr[WB-1];
        end
      end
      if (!prev_cs && cs_n) begin
        if (exp_mosi.size() == 0) chk(0, "R1 unexpected frame", cap, 0);
        else begin
          logic [WB-1:0] e;
          e = exp_mosi.pop_front();
          chk(cap == e, "R1 mosi word", cap, e);
        end
        chk(rises == WB, "R3 sclk rises per word", rises, WB);
        chk(low_cnt == LOW_CYC, "R4 cs_n low time", low_cnt, LOW_CYC);
        slv_k++;
        if (slv_k == NW) last_fall = -1;
      end
      prev_cs = cs_n;
      prev_sclk = sclk;
    end
  end

  // receive-buffer monitor (R2, R8, R9)
  int last_we = -10;
  logic prev_done = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_we) begin
        if (exp_rx.size() == 0) chk(0, "R2 unexpected write", {rx_addr, rx_data}, 0);
        else begin
          logic [19:0] e;
          e = exp_rx.pop_front();
          chk({rx_addr, rx_data} == e, "R2 R8 rx write addr/data", {rx_addr, rx_data}, e);
        end
        if (rx_addr == 4'(NW - 1)) last_we = cyc;
      end
      if (done) begin
        done_cnt++;
        chk(cyc == last_we + 1, "R9 done after last write", cyc, last_we + 1);
        chk(!prev_done, "R9 done width", 2, 1);
      end
      prev_done = done;
    end
  end

  // driver: loads buffers, pushes expectations, fires trigger
  task automatic run_group(input int pat, input bit poke_mid);
    int d0;
    for (int i = 0; i < NW; i++) begin
      case (pat)
        0: begin tx_mem[i] = 16'(i * 16'h1357 + 16'h0101); slv_mem[i] = ~tx_mem[i]; end
        1: begin tx_mem[i] = (i % 2) ? 16'h5555 : 16'hAAAA; slv_mem[i] = 16'(1 << i); end
        default: begin tx_mem[i] = (i % 2) ? 16'h0000 : 16'hFFFF;
                       slv_mem[i] = 16'(i * 16'h0F0F); end
      endcase
      exp_mosi.push_back(tx_mem[i]);
      exp_rx.push_back({4'(i), slv_mem[i]});
    end
    slv_k = 0;
    d0 = done_cnt;
    @(negedge clk) ext_trig = 1'b1;
    @(negedge clk) ext_trig = 1'b0;
    @(negedge clk);
    chk(busy, "R6 busy after trigger", busy, 1);
    if (poke_mid) begin
      repeat (300) @(negedge clk);
      ext_trig = 1'b1;
      @(negedge clk) ext_trig = 1'b0;
    end
    while (busy) @(negedge clk);
    chk(exp_mosi.size() == 0, "R1 all words sent", exp_mosi.size(), 0);
    chk(exp_rx.size() == 0, "R2 all words written", exp_rx.size(), 0);
    chk(done_cnt == d0 + 1, "R9 one done per group", done_cnt - d0, 1);
  endtask

  // internal-trigger instance monitor (R10)
  int rise2[$];
  logic prev_busy2 = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy2 && !prev_busy2) rise2.push_back(cyc);
      prev_busy2 = busy2;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog expired", cyc, 0);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk({cs_n, sclk, mosi, busy, done, rx_we, overrun} == 7'b1000000,
        "R11 reset outputs", {cs_n, sclk, mosi, busy, done, rx_we, overrun}, 7'b1000000);
    ext2 = 1'b1;
    @(negedge clk) ext2 = 1'b0;

    run_group(0, 0);
    run_group(1, 0);           // R8 second group rewinds to word 0
    chk(!overrun, "R7 overrun clear", overrun, 0);

    run_group(2, 1);           // R7 trigger during a group
    chk(overrun, "R7 overrun set", overrun, 1);
    repeat (200) @(negedge clk);
    chk(!busy && cs_n, "R7 ignored trigger starts nothing", {busy, cs_n}, 2'b01);

    run_group(0, 0);           // still runs after overrun
    chk(overrun, "R7 overrun sticky", overrun, 1);

    // R10 internal period, ext_trig ignored on that instance
    while (rise2.size() < 3) begin
      @(negedge clk);
      if (cyc == 3500) ext2 = 1'b1;
      if (cyc == 3501) ext2 = 1'b0;
      if (cyc == 4500) ext2 = 1'b1;
      if (cyc == 4501) ext2 = 1'b0;
    end
    chk(rise2[1] - rise2[0] == PER2, "R10 period 1", rise2[1] - rise2[0], PER2);
    chk(rise2[2] - rise2[1] == PER2, "R10 period 2", rise2[2] - rise2[1], PER2);
    chk(!ovr2, "R10 ext_trig ignored", ovr2, 0);
    finish_run();
  end
endmodule